// File: doc/BRIEF.md
# Timer Channel Byte Access Port

This block sits between an 8-bit processor data bus and one 16-bit down-counting element of an interval timer channel. Software programs a 16-bit start value through byte writes and reads the running value back through byte reads. How many bytes one access takes, and which half each byte carries, is set by an access format. The format is captured whenever the channel's control word is written. Decoding of addresses and of the control word itself happens outside this block, which only receives the resulting strobes and the two-bit format code.

Writes fill a count register. Once the last byte of the selected format arrives, the block issues a one-cycle load strobe with the assembled 16-bit value to the counting element. Reads come from a pair of output latch bytes. These follow the live count on every clock until a latch request freezes them. The frozen value is then kept until software has read it completely or the channel is reprogrammed, so a running count can be sampled without stopping it.

Top module: `timer_byte_port`

## Requirements
- R1: A control-word strobe (`cfgWr`) captures `cfgFmt`. Code 2'b01 selects low byte only, 2'b10 selects high byte only, and any other code (2'b11 or 2'b00) selects low byte then high byte. Reset selects low-then-high. The strobe also returns both the write and the read byte pointer to the low byte and releases any held latch.
- R2: In low-only format, a write makes `loadStb` high for one cycle after the write edge, with `loadVal` = {8'h00, written byte}.
- R3: In high-only format, a write makes `loadStb` high for one cycle after the write edge, with `loadVal` = {written byte, 8'h00}.
- R4: In low-then-high format, the first write gives no strobe. The second write gives a one-cycle `loadStb` with `loadVal` = {second byte, first byte}.
- R5: A write, read or latch request in the same cycle as `cfgWr` has no effect. A control word written between the two bytes of a pair makes the next write a low byte again.
- R6: `rdData` is the output-latch byte that the read pointer selects. In low-then-high format each read strobe alternates low then high. Low-only always gives bits 7:0 and high-only always gives bits 15:8.
- R7: While no latch is held, the output latches take `curCount` on every clock edge. `rdData` therefore shows the count of the preceding cycle.
- R8: A latch request captures `curCount` of the request cycle. Later changes of `curCount` do not alter the read-back value while the latch is held.
- R9: A held latch is released when the read completes (the single read in a one-byte format, the high-byte read in the pair format) or when a control word is written. Tracking resumes from the following clock edge.
- R10: A latch request that arrives while a latched value is still unread is ignored.
- R11: A latch request in the same cycle as the read that completes a held value is accepted. That read returns the old held byte, and the new hold captures `curCount` of that cycle.
- R12: While reset is low, `loadStb`, `loadVal` and `rdData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Control word written to this channel |
| cfgFmt | input | 2 | Access format code taken with `cfgWr` |
| wrEn | input | 1 | Chip-select-qualified write strobe |
| wrData | input | 8 | Write data byte |
| rdEn | input | 1 | Chip-select-qualified read strobe |
| rdData | output | 8 | Read data byte |
| curCount | input | 16 | Live value of the counting element |
| latchReq | input | 1 | Counter latch command for this channel |
| loadStb | output | 1 | One-cycle load strobe to the counting element |
| loadVal | output | 16 | Start value for the counting element |

## Verification
Two functions can fall in the same cycle: the read that completes a held value, and a fresh latch request. The two can also collide with a control-word write. A directed sequence drives a latch, a low read, and then a high read together with a new latch request while `curCount` holds a distinct value. The bench judges that the high byte returned is the old one and that the next reads return the new capture. Random cycles mix reads, latch requests, writes and control words at independent rates. Every cycle is compared against a bench model built from the requirements.

// File: rtl/cntbyte_pkg.sv
package cntbyte_pkg;

  localparam int BYTE_W  = 8;
  localparam int COUNT_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    FMT_LSB  = 2'b01,
    FMT_MSB  = 2'b10,
    FMT_BOTH = 2'b11
  } accFmt_e;

  typedef struct packed {
    logic stLo;       // hold first byte of a pair
    logic ldLo;       // load {0, byte}
    logic ldHi;       // load {byte, 0}
    logic ldPair;     // load {byte, stored low}
    logic olCapture;  // output latch takes curCount at this edge
    logic rdSelHi;    // read mux selects upper byte
  } ctrlStb_t;

  function automatic accFmt_e normFmt(input logic [1:0] code);
    case (code)
      2'b01:   return FMT_LSB;
      2'b10:   return FMT_MSB;
      default: return FMT_BOTH;
    endcase
  endfunction

endpackage

// File: rtl/cntbyte_ctrl.sv
module cntbyte_ctrl
  import cntbyte_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic [1:0] cfgFmt,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       latchReq,
  output ctrlStb_t   stb
);

  accFmt_e fmtQ;
  logic    wrHiQ;
  logic    rdHiQ;
  logic    latchedQ;

  logic    pairFmt;
  logic    wrOk;
  logic    readDone;
  logic    latchAccept;

  always_comb begin
    pairFmt     = (fmtQ == FMT_BOTH);
    wrOk        = wrEn && !cfgWr;
    readDone    = rdEn && !cfgWr && (!pairFmt || rdHiQ);
    latchAccept = latchReq && !cfgWr && (!latchedQ || readDone);

    stb           = '0;
    stb.stLo      = wrOk && pairFmt && !wrHiQ;
    stb.ldLo      = wrOk && (fmtQ == FMT_LSB);
    stb.ldHi      = wrOk && (fmtQ == FMT_MSB);
    stb.ldPair    = wrOk && pairFmt && wrHiQ;
    stb.olCapture = !latchedQ || latchAccept;
    stb.rdSelHi   = (fmtQ == FMT_MSB) || (pairFmt && rdHiQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtQ     <= FMT_BOTH;
      wrHiQ    <= 1'b0;
      rdHiQ    <= 1'b0;
      latchedQ <= 1'b0;
    end else if (cfgWr) begin
      fmtQ     <= normFmt(cfgFmt);
      wrHiQ    <= 1'b0;
      rdHiQ    <= 1'b0;
      latchedQ <= 1'b0;
    end else begin
      if (wrEn && pairFmt) wrHiQ <= !wrHiQ;
      if (rdEn && pairFmt) rdHiQ <= !rdHiQ;
      if (latchAccept)   latchedQ <= 1'b1;
      else if (readDone) latchedQ <= 1'b0;
    end
  end

  // R9
  single_read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchedQ && rdEn && !cfgWr && !latchReq && (fmtQ != FMT_BOTH) |=> !latchedQ);

  // R1
  cfg_resets_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> !wrHiQ && !rdHiQ && !latchedQ);

endmodule

// File: rtl/cntbyte_dp.sv
module cntbyte_dp
  import cntbyte_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [2*DATA_W-1:0] curCount,
  output logic [DATA_W-1:0]   rdData,
  output logic                loadStb,
  output logic [2*DATA_W-1:0] loadVal
);

  localparam int CW = 2 * DATA_W;

  logic [DATA_W-1:0] crLoQ;
  logic [CW-1:0]     olQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crLoQ   <= '0;
      olQ     <= '0;
      loadStb <= 1'b0;
      loadVal <= '0;
    end else begin
      if (stb.stLo)      crLoQ <= wrData;
      if (stb.olCapture) olQ   <= curCount;
      loadStb <= stb.ldLo || stb.ldHi || stb.ldPair;
      if (stb.ldLo)        loadVal <= {{DATA_W{1'b0}}, wrData};
      else if (stb.ldHi)   loadVal <= {wrData, {DATA_W{1'b0}}};
      else if (stb.ldPair) loadVal <= {wrData, crLoQ};
    end
  end

  assign rdData = stb.rdSelHi ? olQ[CW-1:DATA_W] : olQ[DATA_W-1:0];

  // R4
  pair_low_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldPair |=> loadStb && (loadVal[DATA_W-1:0] == $past(crLoQ)));

endmodule

// File: rtl/timer_byte_port.sv
module timer_byte_port
  import cntbyte_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWr,
  input  logic [1:0]   cfgFmt,
  input  logic         wrEn,
  input  logic [7:0]   wrData,
  input  logic         rdEn,
  output logic [7:0]   rdData,
  input  logic [15:0]  curCount,
  input  logic         latchReq,
  output logic         loadStb,
  output logic [15:0]  loadVal
);

  ctrlStb_t stb;

  cntbyte_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWr    (cfgWr),
    .cfgFmt   (cfgFmt),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .latchReq (latchReq),
    .stb      (stb)
  );

  cntbyte_dp #(.DATA_W(BYTE_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .curCount (curCount),
    .rdData   (rdData),
    .loadStb  (loadStb),
    .loadVal  (loadVal)
  );

  // R2
  lsb_only_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !cfgWr && (i_ctrl.fmtQ == FMT_LSB) |=> loadStb && (loadVal == {8'h00, $past(wrData)}));

  // R3
  msb_only_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !cfgWr && (i_ctrl.fmtQ == FMT_MSB) |=> loadStb && (loadVal == {$past(wrData), 8'h00}));

  // R4
  pair_first_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !cfgWr && (i_ctrl.fmtQ == FMT_BOTH) && !i_ctrl.wrHiQ |=> !loadStb);

  // R5
  cfg_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> !loadStb);

  // R7
  track_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !i_ctrl.latchedQ && !cfgWr && (i_ctrl.fmtQ == FMT_LSB) |=> rdData == $past(curCount[7:0]));

  // R8
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    i_ctrl.latchedQ && !rdEn && !cfgWr |=> $stable(i_dp.olQ));

endmodule

// File: tb/test_timer_byte_port.sv
module test_timer_byte_port;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWr;
  logic [1:0]  cfgFmt;
  logic        wrEn;
  logic [7:0]  wrData;
  logic        rdEn;
  logic [7:0]  rdData;
  logic [15:0] curCount;
  logic        latchReq;
  logic        loadStb;
  logic [15:0] loadVal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0]  mFmt;
  bit          mWrHi, mRdHi, mHeld, mStb;
  logic [7:0]  mLo;
  logic [15:0] mOl, mVal;

  always #5 clk = ~clk;

  timer_byte_port i_timer_byte_port (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgFmt(cfgFmt),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .curCount(curCount), .latchReq(latchReq),
    .loadStb(loadStb), .loadVal(loadVal)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] expRd();
    if (mFmt == 2'b01) return mOl[7:0];
    if (mFmt == 2'b10) return mOl[15:8];
    return mRdHi ? mOl[15:8] : mOl[7:0];
  endfunction

  task automatic modelEdge();
    bit done1, take;
    done1 = rdEn && !cfgWr && (mFmt != 2'b11 || mRdHi);
    take  = latchReq && !cfgWr && (!mHeld || done1);
    mStb  = 1'b0;
    if (!mHeld || take) mOl = curCount;
    if (cfgWr) begin
      mFmt  = (cfgFmt == 2'b01 || cfgFmt == 2'b10) ? cfgFmt : 2'b11;
      mWrHi = 0; mRdHi = 0; mHeld = 0;
    end else begin
      if (wrEn) begin
        if (mFmt == 2'b01) begin mStb = 1; mVal = {8'h00, wrData}; end
        else if (mFmt == 2'b10) begin mStb = 1; mVal = {wrData, 8'h00}; end
        else if (!mWrHi) begin mLo = wrData; mWrHi = 1; end
        else begin mStb = 1; mVal = {wrData, mLo}; mWrHi = 0; end
      end
      if (rdEn && mFmt == 2'b11) mRdHi = !mRdHi;
      if (take) mHeld = 1;
      else if (done1) mHeld = 0;
    end
  endtask

  task automatic step(input string tag, input bit c, input logic [1:0] f,
                      input bit w, input logic [7:0] d, input bit r,
                      input bit l, input logic [15:0] cnt);
    @(negedge clk);
    cfgWr = c; cfgFmt = f; wrEn = w; wrData = d; rdEn = r; latchReq = l; curCount = cnt;
    #1;
    check({tag, " rdData"}, {8'h00, rdData}, {8'h00, expRd()});
    @(posedge clk);
    #1;
    modelEdge();
    check({tag, " loadStb"}, {15'h0, loadStb}, {15'h0, mStb});
    check({tag, " loadVal"}, loadVal, mVal);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int seedV;
    seedV = $urandom(32'h5eed);
    rstN = 0; cfgWr = 0; cfgFmt = 0; wrEn = 0; wrData = 0; rdEn = 0;
    latchReq = 0; curCount = 16'h0;
    mFmt = 2'b11; mWrHi = 0; mRdHi = 0; mHeld = 0; mStb = 0; mLo = 0; mOl = 0; mVal = 0;
    repeat (2) @(posedge clk);
    #2;
    // R12 reset outputs
    check("R12 loadStb", {15'h0, loadStb}, 16'h0);
    check("R12 loadVal", loadVal, 16'h0);
    check("R12 rdData", {8'h00, rdData}, 16'h0);
    @(negedge clk);
    rstN = 1;

    // R7 tracking
    step("R7", 0, 0, 0, 0, 0, 0, 16'hABCD);
    check("R7 live low", {8'h00, rdData}, 16'h00CD);
    step("R6", 0, 0, 0, 0, 1, 0, 16'hABCD);
    check("R6 high after low", {8'h00, rdData}, 16'h00AB);
    step("R6", 0, 0, 0, 0, 1, 0, 16'hABCD);

    // R8 latch, R10 ignored second latch
    step("R8", 0, 0, 0, 0, 0, 1, 16'h1111);
    step("R8", 0, 0, 0, 0, 0, 0, 16'h2222);
    check("R8 frozen low", {8'h00, rdData}, 16'h0011);
    step("R10", 0, 0, 0, 0, 0, 1, 16'h3333);
    step("R10", 0, 0, 0, 0, 1, 0, 16'h2222);
    check("R10 second latch ignored", {8'h00, rdData}, 16'h0011);

    // R11 completing read with new latch
    step("R11", 0, 0, 0, 0, 1, 1, 16'h4444);
    step("R11", 0, 0, 0, 0, 0, 0, 16'h5555);
    check("R11 new hold low", {8'h00, rdData}, 16'h0044);
    step("R11", 0, 0, 0, 0, 1, 0, 16'h5555);
    check("R11 new hold high", {8'h00, rdData}, 16'h0044);
    step("R9", 0, 0, 0, 0, 1, 0, 16'h5555);
    step("R9", 0, 0, 0, 0, 0, 0, 16'h6666);
    check("R9 tracking resumes", {8'h00, rdData}, 16'h0066);

    // R4 pair writes
    step("R4", 0, 0, 1, 8'h34, 0, 0, 16'h0);
    check("R4 no strobe after first", {15'h0, loadStb}, 16'h0);
    step("R4", 0, 0, 1, 8'h12, 0, 0, 16'h0);
    check("R4 pair strobe", {15'h0, loadStb}, 16'h1);
    check("R4 pair value", loadVal, 16'h1234);

    // R5 pointer reset by control word
    step("R5", 0, 0, 1, 8'h77, 0, 0, 16'h0);
    step("R5", 1, 2'b11, 0, 0, 0, 0, 16'h0);
    step("R5", 0, 0, 1, 8'h11, 0, 0, 16'h0);
    check("R5 restart low byte", {15'h0, loadStb}, 16'h0);
    step("R5", 0, 0, 1, 8'h22, 0, 0, 16'h0);
    check("R5 pair after reset", loadVal, 16'h2211);
    step("R5", 1, 2'b01, 1, 8'h99, 0, 0, 16'h0);
    check("R5 write with cfg dropped", {15'h0, loadStb}, 16'h0);

    // R2 low only
    step("R2", 0, 0, 1, 8'h5A, 0, 0, 16'hBEEF);
    check("R2 low-only value", loadVal, 16'h005A);
    step("R6", 0, 0, 0, 0, 1, 0, 16'hBEEF);
    check("R6 low-only read", {8'h00, rdData}, 16'h00EF);

    // R3 high only
    step("R3", 1, 2'b10, 0, 0, 0, 0, 16'hBEEF);
    step("R3", 0, 0, 1, 8'hC3, 0, 0, 16'hBEEF);
    check("R3 high-only value", loadVal, 16'hC300);
    check("R6 high-only read", {8'h00, rdData}, 16'h00BE);

    // R1 code 00 selects pair format
    step("R1", 1, 2'b00, 0, 0, 0, 0, 16'h0);
    step("R1", 0, 0, 1, 8'h01, 0, 0, 16'h0);
    check("R1 code 00 is pair", {15'h0, loadStb}, 16'h0);

    // R9 release by control word
    step("R9", 0, 0, 0, 0, 0, 1, 16'h7777);
    step("R9", 1, 2'b11, 0, 0, 0, 0, 16'h7777);
    step("R9", 0, 0, 0, 0, 0, 0, 16'h8888);
    check("R9 cfg releases", {8'h00, rdData}, 16'h0088);

    // random mix, R6 R7 R8 R10 R11 against model
    for (int i = 0; i < 3000; i++) begin
      step("R11 random", ($urandom % 40) == 0, 2'($urandom),
           ($urandom % 4) == 0, 8'($urandom), ($urandom % 3) == 0,
           ($urandom % 6) == 0, 16'($urandom));
    end
    step("R6", 0, 0, 0, 0, 0, 0, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule